// File: doc/BRIEF.md
# Logarithmic Arithmetic Unit

This block evaluates multiplicative functions of positive fixed-point numbers without a multiplier array or an iterative divider. Each incoming operand is turned into a base-2 logarithm. The requested function then becomes an add, a subtract, a negation or a one-place shift of those logarithms. An exponential stage turns the outcome back into a fixed-point number.

Both conversions split the fractional curve into eight segments. Each segment has its own starting value and its own slope, so a conversion is a short multiply-add rather than a long series.

Operands are unsigned Q8.8 values: 16 bits, of which 8 are fractional bits. Results use the same format. One operation can be issued per clock, and its result appears two clocks later together with a one-cycle valid strobe. The block does not add or subtract ordinary numbers. Signed operands are not handled, apart from flagging zero operands.

Top module: `log_arith_unit`

## Requirements
- R1: `in_ready_o` is 0 while `rst_i` is high and 1 from the first clock after reset is released. Every cycle with `in_valid_i` and `in_ready_o` high accepts one operation, back to back.
- R2: The result of an operation accepted at clock edge N is presented on `res_o` and `invalid_o`, with `res_valid_o` high, after edge N+2. `res_valid_o` is low in every cycle that has no such result.
- R3: Opcode 0 (product) returns a·b to within 2 % of the true value plus 2 LSB.
- R4: Opcode 1 (quotient) returns a/b within the same tolerance.
- R5: Opcode 2 (inverse) returns 1/a within the same tolerance.
- R6: Opcode 3 returns √a, and opcode 4 returns 1/√a, within the same tolerance.
- R7: Opcode 5 returns a² within the same tolerance.
- R8: If every operand the opcode uses is an exact power of two and the true result is also a power of two, the result is exact: the true value rounded down to an integer LSB count.
- R9: A true result above 0xFFFF returns 0xFFFF. A true result below 1 LSB returns 0 or at most 2 LSB, and returns exactly 0 when it is a power of two.
- R10: `invalid_o` is 1 when an operand used by the opcode is zero. A zero divisor for opcode 1, or a zero operand for opcodes 2 or 4, returns 0xFFFF. Any other zero operand returns 0.
- R11: Opcodes 6 and 7 are reserved. They return 0 with `invalid_o` set to 1.
- R12: For the single-operand opcodes 2 to 5, `b_i` has no effect on `res_o` or on `invalid_o`, including when `b_i` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | An operation is offered |
| in_ready_o | output | 1 | The unit accepts an operation this cycle |
| op_i | input | 3 | Opcode (0 product, 1 quotient, 2 inverse, 3 root, 4 inverse root, 5 square) |
| a_i | input | 16 | First operand, unsigned Q8.8 |
| b_i | input | 16 | Second operand, unsigned Q8.8 (product and quotient only) |
| res_valid_o | output | 1 | Result strobe |
| res_o | output | 16 | Result, unsigned Q8.8, saturating |
| invalid_o | output | 1 | A used operand was zero, or the opcode is reserved |

## Verification
A wrong segment coefficient shows up only for operands whose mantissa falls in that segment. Random operands spanning all magnitudes therefore hit every segment of both converters, and the error shows as a result outside the tolerance on the same strobe. A mistake in the log-domain operation or in the exponent shift gives results that are wrong by a factor of two or more. Power-of-two operands make such a mistake visible as a non-zero difference in the exact checks. A broken pipeline stage pairs a result with the wrong operation, or moves the strobe. The strobe is compared against the issue pattern two cycles earlier, so this is caught at the first mismatched cycle.

// File: rtl/lau_pkg.sv
package lau_pkg;

    localparam int LOG_FRAC = 12;
    localparam int LOG_INT  = 5;
    localparam int LOG_W    = LOG_INT + LOG_FRAC;
    localparam int SEG_BITS = 3;
    localparam int POS_W    = LOG_FRAC - SEG_BITS;
    localparam int COEF_W   = 13;
    localparam int PROD_W   = COEF_W + POS_W;

    typedef logic signed [LOG_W-1:0] log_t;

    typedef enum logic [2:0] {
        OP_MUL   = 3'd0,
        OP_DIV   = 3'd1,
        OP_RCP   = 3'd2,
        OP_SQRT  = 3'd3,
        OP_RSQRT = 3'd4,
        OP_SQR   = 3'd5
    } lau_op_e;

    typedef struct packed {
        logic [COEF_W-1:0] base;
        logic [COEF_W-1:0] slope;
    } seg_t;

    typedef struct packed {
        logic    vld;
        lau_op_e op;
        logic    za;
        logic    zb;
        log_t    la;
        log_t    lb;
    } s1_t;

    // log2(1+f) chord segments, Q12: value at segment start, slope
    function automatic seg_t log_seg(input logic [SEG_BITS-1:0] idx);
        seg_t s;
        case (idx)
            3'd0: s = '{base: 13'd0,    slope: 13'd5568};
            3'd1: s = '{base: 13'd696,  slope: 13'd4984};
            3'd2: s = '{base: 13'd1319, slope: 13'd4504};
            3'd3: s = '{base: 13'd1882, slope: 13'd4112};
            3'd4: s = '{base: 13'd2396, slope: 13'd3784};
            3'd5: s = '{base: 13'd2869, slope: 13'd3504};
            3'd6: s = '{base: 13'd3307, slope: 13'd3264};
            default: s = '{base: 13'd3715, slope: 13'd3048};
        endcase
        return s;
    endfunction

    // 2^f - 1 chord segments, Q12
    function automatic seg_t exp_seg(input logic [SEG_BITS-1:0] idx);
        seg_t s;
        case (idx)
            3'd0: s = '{base: 13'd0,    slope: 13'd2968};
            3'd1: s = '{base: 13'd371,  slope: 13'd3232};
            3'd2: s = '{base: 13'd775,  slope: 13'd3528};
            3'd3: s = '{base: 13'd1216, slope: 13'd3848};
            3'd4: s = '{base: 13'd1697, slope: 13'd4192};
            3'd5: s = '{base: 13'd2221, slope: 13'd4576};
            3'd6: s = '{base: 13'd2793, slope: 13'd4984};
            default: s = '{base: 13'd3416, slope: 13'd5440};
        endcase
        return s;
    endfunction

    // base + slope * pos / 2^LOG_FRAC, never reaches 2^LOG_FRAC
    function automatic logic [LOG_FRAC-1:0] seg_eval(input seg_t s,
                                                     input logic [POS_W-1:0] pos);
        logic [PROD_W-1:0] prod;
        prod = PROD_W'(s.slope) * PROD_W'(pos);
        return LOG_FRAC'(s.base + COEF_W'(prod >> LOG_FRAC));
    endfunction

endpackage

// File: rtl/lau_log_conv.sv
module lau_log_conv
    import lau_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int FRAC_W = 8
) (
    input  logic [DATA_W-1:0] x_i,
    output log_t              lg_o,
    output logic              zero_o
);
    localparam int IDX_W = $clog2(DATA_W);

    logic [IDX_W-1:0]          msb;
    logic [LOG_FRAC-1:0]       mant;
    logic [LOG_FRAC-1:0]       frac;
    logic signed [LOG_INT-1:0] ipart;

    always_comb begin
        msb = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (x_i[i]) msb = IDX_W'(i);
        end
    end

    // bits directly below the leading one, left aligned
    assign mant  = LOG_FRAC'(({x_i, {LOG_FRAC{1'b0}}} << (DATA_W - 1 - int'(msb))) >> (DATA_W - 1));
    assign frac  = seg_eval(log_seg(mant[LOG_FRAC-1 -: SEG_BITS]), mant[POS_W-1:0]);
    assign ipart = LOG_INT'(int'(msb) - FRAC_W);
    assign lg_o  = {ipart, frac};
    assign zero_o = (x_i == '0);

    always_comb begin
        if (!zero_o && $countones(x_i) == 1) begin
            // R8
            pow2_log_chk: assert (frac == '0);
        end
    end

endmodule

// File: rtl/lau_log_op.sv
module lau_log_op
    import lau_pkg::*;
(
    input  lau_op_e op_i,
    input  log_t    la_i,
    input  log_t    lb_i,
    output log_t    lr_o
);
    always_comb begin
        case (op_i)
            OP_MUL:   lr_o = la_i + lb_i;
            OP_DIV:   lr_o = la_i - lb_i;
            OP_RCP:   lr_o = -la_i;
            OP_SQRT:  lr_o = la_i >>> 1;
            OP_RSQRT: lr_o = -(la_i >>> 1);
            OP_SQR:   lr_o = la_i <<< 1;
            default:  lr_o = '0;
        endcase
    end
endmodule

// File: rtl/lau_antilog_conv.sv
module lau_antilog_conv
    import lau_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int FRAC_W = 8
) (
    input  log_t              lg_i,
    output logic [DATA_W-1:0] val_o
);
    localparam int MANT_W = LOG_FRAC + 1;
    localparam int MAX_SH = DATA_W - MANT_W;

    logic signed [LOG_INT-1:0] ipart;
    logic [LOG_FRAC-1:0]       frac;
    logic [MANT_W-1:0]         mant;
    int                        sh;

    assign ipart = lg_i[LOG_W-1:LOG_FRAC];
    assign frac  = lg_i[LOG_FRAC-1:0];
    assign mant  = {1'b1, seg_eval(exp_seg(frac[LOG_FRAC-1 -: SEG_BITS]), frac[POS_W-1:0])};
    assign sh    = int'(ipart) + FRAC_W - LOG_FRAC;

    always_comb begin
        if (sh > MAX_SH) begin
            val_o = '1;
        end else if (sh >= 0) begin
            val_o = DATA_W'(mant) << sh;
        end else if (-sh >= MANT_W) begin
            val_o = '0;
        end else begin
            val_o = DATA_W'(mant >> (-sh));
        end
    end

    always_comb begin
        if (frac == '0 && sh >= 0 && sh <= MAX_SH) begin
            // R8
            pow2_exp_chk: assert ($countones(val_o) == 1);
        end
    end

endmodule

// File: rtl/log_arith_unit.sv
module log_arith_unit
    import lau_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int FRAC_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic              res_valid_o,
    output logic [DATA_W-1:0] res_o,
    output logic              invalid_o
);
    localparam int N_OPND = 2;

    logic [DATA_W-1:0] opnd [N_OPND];
    log_t              lg   [N_OPND];
    logic              zr   [N_OPND];

    assign opnd[0] = a_i;
    assign opnd[1] = b_i;

    for (genvar g = 0; g < N_OPND; g++) begin : g_conv
        lau_log_conv #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_log (
            .x_i   (opnd[g]),
            .lg_o  (lg[g]),
            .zero_o(zr[g])
        );
    end

    // stage 1: logarithms of the operands
    s1_t  s1_q;
    logic ready_q;
    logic fire;

    assign fire       = in_valid_i && ready_q;
    assign in_ready_o = ready_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s1_q    <= '0;
            ready_q <= 1'b0;
        end else begin
            ready_q   <= 1'b1;
            s1_q.vld  <= fire;
            if (fire) begin
                s1_q.op <= lau_op_e'(op_i);
                s1_q.za <= zr[0];
                s1_q.zb <= zr[1];
                s1_q.la <= lg[0];
                s1_q.lb <= lg[1];
            end
        end
    end

    // stage 2: log-domain operation, exponential, special cases
    log_t              lr;
    logic [DATA_W-1:0] lin;
    logic              reserved, uses_b, inv_d;
    logic [DATA_W-1:0] res_d;

    lau_log_op u_op (
        .op_i(s1_q.op),
        .la_i(s1_q.la),
        .lb_i(s1_q.lb),
        .lr_o(lr)
    );

    lau_antilog_conv #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_exp (
        .lg_i (lr),
        .val_o(lin)
    );

    always_comb begin
        reserved = !(s1_q.op inside {OP_MUL, OP_DIV, OP_RCP, OP_SQRT, OP_RSQRT, OP_SQR});
        uses_b   = (s1_q.op == OP_MUL) || (s1_q.op == OP_DIV);
        inv_d    = reserved || s1_q.za || (uses_b && s1_q.zb);
        res_d    = lin;
        if (reserved)
            res_d = '0;
        else if (s1_q.op == OP_DIV && s1_q.zb)
            res_d = '1;
        else if ((s1_q.op == OP_RCP || s1_q.op == OP_RSQRT) && s1_q.za)
            res_d = '1;
        else if (s1_q.za || (uses_b && s1_q.zb))
            res_d = '0;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            res_valid_o <= 1'b0;
            res_o       <= '0;
            invalid_o   <= 1'b0;
        end else begin
            res_valid_o <= s1_q.vld;
            if (s1_q.vld) begin
                res_o     <= res_d;
                invalid_o <= inv_d;
            end
        end
    end

    // R1
    ready_after_rst_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> in_ready_o);

    // R2
    two_cycle_lat_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        res_valid_o == $past(in_valid_i && in_ready_o, 2));

    // R10
    div_zero_sat_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (res_valid_o && $past(in_valid_i && in_ready_o && op_i == OP_DIV && b_i == '0, 2))
        |-> (res_o == '1 && invalid_o));

    // R11
    reserved_op_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (res_valid_o && $past(in_valid_i && in_ready_o && op_i[2] && op_i[1], 2))
        |-> (res_o == '0 && invalid_o));

endmodule

// File: tb/log_arith_unit_tb_top.sv
`timescale 1ns/1ps
module log_arith_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  op_s = '0;
    logic [15:0] a_s = '0, b_s = '0;
    logic        res_valid;
    logic [15:0] res;
    logic        invalid;

    always #2 clk = ~clk;

    log_arith_unit dut_i (
        .clk_i(clk), .rst_i(rst), .in_valid_i(in_valid), .in_ready_o(in_ready),
        .op_i(op_s), .a_i(a_s), .b_i(b_s),
        .res_valid_o(res_valid), .res_o(res), .invalid_o(invalid)
    );

    int    n_chk = 0, n_bad = 0;
    bit    done = 0;
    real   max_rel [8];
    bit    pv [2];
    int    pop [2], pa [2], pb [2];
    string ptag [2];

    function automatic bit pow2i(int v);
        return v != 0 && (v & (v - 1)) == 0;
    endfunction

    function automatic bit pow2r(real e);
        real p;
        if (e <= 0.0) return 0;
        p = 1.0;
        while (p < e) p = p * 2.0;
        while (p > e) p = p / 2.0;
        return p == e;
    endfunction

    function automatic string optag(int op);
        case (op)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3, 4: return "R6";
            5: return "R7";
            default: return "R11";
        endcase
    endfunction

    // expected result in LSB units from the requirements
    task automatic model(input int op, input int a, input int b,
                         output real e, output bit inv, output bit exact);
        real x, y;
        bit  zs;
        x = a / 256.0;
        y = b / 256.0;
        inv = 0; exact = 0; e = 0.0; zs = 0;
        case (op)
            0: begin inv = (a == 0 || b == 0); zs = inv; if (!inv) e = x * y * 256.0; end
            1: begin
                inv = (a == 0 || b == 0);
                if (b == 0) begin e = 65535.0; zs = 1; end
                else if (a == 0) zs = 1;
                else e = x / y * 256.0;
            end
            2: begin inv = (a == 0); if (inv) begin e = 65535.0; zs = 1; end else e = 256.0 / x; end
            3: begin inv = (a == 0); zs = inv; if (!inv) e = $sqrt(x) * 256.0; end
            4: begin inv = (a == 0); if (inv) begin e = 65535.0; zs = 1; end else e = 256.0 / $sqrt(x); end
            5: begin inv = (a == 0); zs = inv; if (!inv) e = x * x * 256.0; end
            default: begin inv = 1; zs = 1; end
        endcase
        exact = zs;
        if (!zs && pow2i(a) && (op > 1 || pow2i(b)) && pow2r(e)) exact = 1;
        if (e > 65535.0) e = 65535.0;
    endtask

    task automatic check_slot();
        real   e, diff, rel;
        bit    inv, ex, ok;
        int    got;
        string tg;
        n_chk++;
        if (pv[1]) begin
            model(pop[1], pa[1], pb[1], e, inv, ex);
            got  = int'(res);
            diff = (got > e) ? got - e : e - got;
            tg   = (ptag[1] == "") ? optag(pop[1]) : ptag[1];
            if (ex) ok = (got == $rtoi(e));
            else    ok = (diff <= 0.02 * e + 2.0);
            ok = ok && res_valid && (invalid == inv);
            if (!ex && e >= 64.0 && e < 65535.0) begin
                rel = diff / e;
                if (rel > max_rel[pop[1]]) max_rel[pop[1]] = rel;
            end
            if (!ok) begin
                n_bad++;
                $display("FAIL %s op=%0d a=%h b=%h: got res=%0d valid=%b inv=%b, expected res=%0.2f%s valid=1 inv=%b",
                         tg, pop[1], pa[1][15:0], pb[1][15:0], got, res_valid, invalid, e,
                         ex ? " exact" : "", inv);
            end
        end else if (res_valid) begin
            n_bad++;
            $display("FAIL R2 idle slot: got res_valid=1, expected 0");
        end
    endtask

    task automatic step(input bit v, input int op, input int a, input int b, input string tag);
        @(negedge clk);
        check_slot();
        pv[1] = pv[0]; pop[1] = pop[0]; pa[1] = pa[0]; pb[1] = pb[0]; ptag[1] = ptag[0];
        pv[0] = v;     pop[0] = op;     pa[0] = a;     pb[0] = b;     ptag[0] = tag;
        in_valid = v;
        op_s = 3'(op);
        a_s  = 16'(a);
        b_s  = 16'(b);
    endtask

    function automatic int rnd_opnd();
        int w;
        w = int'($urandom_range(1, 16));
        return int'($urandom & ((32'd1 << w) - 1));
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got run still active, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_2024));
        for (int i = 0; i < 8; i++) max_rel[i] = 0.0;
        for (int i = 0; i < 2; i++) begin pv[i] = 0; ptag[i] = ""; end

        // reset state, R1 and R2
        repeat (3) begin
            @(negedge clk);
            n_chk++;
            if (in_ready !== 1'b0 || res_valid !== 1'b0 || res !== 16'h0 || invalid !== 1'b0) begin
                n_bad++;
                $display("FAIL R1 reset state: got ready=%b valid=%b res=%h inv=%b, expected 0 0 0000 0",
                         in_ready, res_valid, res, invalid);
            end
        end
        rst = 1'b0;
        @(negedge clk);
        n_chk++;
        if (in_ready !== 1'b1) begin
            n_bad++;
            $display("FAIL R1 ready after reset: got %b, expected 1", in_ready);
        end

        // R8 exact powers of two
        step(1, 0, 16'h0200, 16'h0400, "R8");
        step(1, 1, 16'h0400, 16'h0100, "R8");
        step(1, 2, 16'h0200, 16'h1234, "R8");
        step(1, 3, 16'h0400, 16'h0000, "R8");
        step(1, 4, 16'h0400, 16'h0000, "R8");
        step(1, 5, 16'h0800, 16'h0000, "R8");
        step(1, 4, 16'h0001, 16'h0000, "R8");
        step(1, 1, 16'h0010, 16'h8000, "R8");
        // R9 saturation and underflow
        step(1, 0, 16'hFFFF, 16'hFFFF, "R9");
        step(1, 5, 16'h1000, 16'h0000, "R9");
        step(1, 2, 16'h0001, 16'h0000, "R9");
        step(1, 0, 16'h0001, 16'h0001, "R9");
        step(1, 1, 16'h0003, 16'hF000, "R9");
        // R10 zero operands
        step(1, 1, 16'h0500, 16'h0000, "R10");
        step(1, 1, 16'h0000, 16'h0000, "R10");
        step(1, 1, 16'h0000, 16'h0700, "R10");
        step(1, 2, 16'h0000, 16'h0100, "R10");
        step(1, 4, 16'h0000, 16'h0100, "R10");
        step(1, 0, 16'h0000, 16'h0300, "R10");
        step(1, 0, 16'h0300, 16'h0000, "R10");
        step(1, 3, 16'h0000, 16'h0300, "R10");
        step(1, 5, 16'h0000, 16'h0300, "R10");
        // R11 reserved opcodes
        step(1, 6, 16'h0100, 16'h0100, "R11");
        step(1, 7, 16'h2000, 16'h0000, "R11");
        // R12 second operand ignored by unary opcodes
        step(1, 2, 16'h0300, 16'h0000, "R12");
        step(1, 2, 16'h0300, 16'hFFFF, "R12");
        step(1, 3, 16'h0A00, 16'h0000, "R12");
        step(1, 5, 16'h0180, 16'h0000, "R12");
        step(1, 4, 16'h7777, 16'h0000, "R12");
        step(0, 0, 0, 0, "");

        // constrained random, R3 to R7 and R2 bubbles
        for (int n = 0; n < 4000; n++) begin
            int r, op;
            r  = int'($urandom_range(0, 99));
            op = (r < 4) ? 6 + (r & 1) : int'($urandom_range(0, 5));
            if (r >= 4 && r < 10) step(0, 0, 0, 0, "");
            else                  step(1, op, rnd_opnd(), rnd_opnd(), "");
        end
        step(0, 0, 0, 0, "");
        step(0, 0, 0, 0, "");
        step(0, 0, 0, 0, "");

        for (int k = 0; k < 6; k++)
            $display("opcode %0d: max relative error %f", k, max_rel[k]);
        done = 1;
        summary();
        $finish;
    end

endmodule